// File: doc/BRIEF.md
# Vector scalar operand formatter

This block sits in the issue path of a vector unit. It receives the 3-bit operand-pattern field of a vector arithmetic instruction together with every scalar source the instruction could use: the 5-bit immediate, an integer register value and a floating-point register value. It works out the operand class and produces one element-width scalar that the lanes can broadcast.

The element width is given as a 2-bit code. Integer sources are cut down or sign-extended to that width. A floating-point source is checked for correct NaN-boxing, and the canonical quiet NaN of the element width replaces it if the check fails. The block also raises a reserved-instruction flag for the two floating-point patterns when the dynamic rounding mode is invalid or the element width is not a supported floating-point width. This flag does not depend on the operation or on the vector length.

All outputs are registered, so they appear one clock after the inputs. The integer register width is set by the parameter `XLEN` (default 32). The floating-point register width is set by `FLEN` (default 64). The output is always 64 bits wide.

Top module: `vec_scalar_fmt`

## Requirements
- R1: Operand class `cls_o` follows `funct3_i`. Codes 000, 001 and 010 give class 0 (vector-vector). 011 gives class 1 (immediate). 100 and 110 give class 2 (integer scalar). 101 gives class 3 (FP scalar). 111 gives class 4 (configuration).
- R2: `sew_i` codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. Every bit of `scalar_o` at or above the selected width is zero.
- R3: For class 1, `scalar_o` is `imm_i` sign-extended from bit 4 to the element width.
- R4: For class 2 with an element width no wider than `XLEN`, `scalar_o` is the low element-width bits of `xreg_i`.
- R5: For class 2 with an element width wider than `XLEN`, `scalar_o` is `xreg_i` sign-extended from bit `XLEN-1` to the element width.
- R6: For class 3, when every bit of `freg_i` from the element width up to bit `FLEN-1` is one, `scalar_o` is the low element-width bits of `freg_i`. The check always passes when the element width equals `FLEN`.
- R7: For class 3, when that boxing check fails, `scalar_o` is the canonical NaN: 0x7E00 for 16 bits, 0x7FC00000 for 32 bits and 0x7FF8000000000000 for 64 bits.
- R8: For `funct3_i` 001 or 101, a rounding mode `frm_i` of 5, 6 or 7 sets `rsvd_o`. Rounding modes have no effect on the other patterns.
- R9: For `funct3_i` 001 or 101, `rsvd_o` is set when the element width is not a supported FP width. `fp_ok_i` bit 0, 1 and 2 mark 16-, 32- and 64-bit support. An 8-bit width and any width above `FLEN` are never supported.
- R10: `scalar_o` is zero whenever `rsvd_o` is set, and it is zero for classes 0 and 4.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| funct3_i | input | 3 | Operand-pattern field |
| imm_i | input | 5 | Immediate field |
| xreg_i | input | XLEN | Integer register value |
| freg_i | input | FLEN | Floating-point register value |
| sew_i | input | 2 | Element width code (8 << code bits) |
| frm_i | input | 3 | Dynamic rounding mode |
| fp_ok_i | input | 3 | Supported FP widths (16, 32, 64) |
| scalar_o | output | 64 | Formatted scalar, zero above element width |
| cls_o | output | 3 | Operand class code |
| rsvd_o | output | 1 | Reserved-instruction flag |

## Verification
The block holds no state beyond one output register. Any fault therefore shows on the ports in the cycle right after the input pattern that triggers it. A wrong width mask shows up as stray upper bits. A wrong extension source shows up as upper bits that do not follow bit 4, bit `XLEN-1` or the boxing result. A wrong reserved decode shows up as a flag on an integer pattern, or a missing flag on an FP pattern with a bad rounding mode or width. Random stimulus biases the FP register toward correctly boxed values, so both the pass and fail branches of the boxing check are reached at every width.

// File: rtl/vec_scalar_fmt.sv
module vec_scalar_fmt #(
  parameter int XLEN = 32,
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      funct3_i,
  input  logic [4:0]      imm_i,
  input  logic [XLEN-1:0] xreg_i,
  input  logic [FLEN-1:0] freg_i,
  input  logic [1:0]      sew_i,
  input  logic [2:0]      frm_i,
  input  logic [2:0]      fp_ok_i,
  output logic [63:0]     scalar_o,
  output logic [2:0]      cls_o,
  output logic            rsvd_o
);
  localparam int ELEN = 64;

  logic [ELEN-1:0] wmask, x_ext, f_ext, imm_ext, canon, val;
  logic [2:0]      cls;
  logic            is_fp, width_ok, box_ok, rsvd;
  logic [7:0]      sew_bits;

  assign sew_bits = 8'd8 << sew_i;
  assign imm_ext  = {{(ELEN-5){imm_i[4]}}, imm_i};

  generate
    if (XLEN >= ELEN) begin : g_xwide
      assign x_ext = xreg_i[ELEN-1:0];
    end else begin : g_xnarrow
      assign x_ext = {{(ELEN-XLEN){xreg_i[XLEN-1]}}, xreg_i};
    end
    if (FLEN >= ELEN) begin : g_fwide
      assign f_ext = freg_i[ELEN-1:0];
    end else begin : g_fnarrow
      assign f_ext = {{(ELEN-FLEN){1'b1}}, freg_i};
    end
  endgenerate

  always_comb begin
    case (sew_i)
      2'd0:    begin wmask = 64'h0000_0000_0000_00FF; canon = '0; end
      2'd1:    begin wmask = 64'h0000_0000_0000_FFFF; canon = 64'h7E00; end
      2'd2:    begin wmask = 64'h0000_0000_FFFF_FFFF; canon = 64'h7FC0_0000; end
      default: begin wmask = '1;                      canon = 64'h7FF8_0000_0000_0000; end
    endcase
  end

  always_comb begin
    case (sew_i)
      2'd1:    width_ok = fp_ok_i[0];
      2'd2:    width_ok = fp_ok_i[1];
      2'd3:    width_ok = fp_ok_i[2];
      default: width_ok = 1'b0;
    endcase
    if (int'(sew_bits) > FLEN) width_ok = 1'b0;
  end

  assign box_ok = &(f_ext | wmask);
  assign is_fp  = (funct3_i == 3'b001) || (funct3_i == 3'b101);
  assign rsvd   = is_fp && ((frm_i >= 3'd5) || !width_ok);

  always_comb begin
    cls = 3'd0;
    val = '0;
    case (funct3_i)
      3'b011:         begin cls = 3'd1; val = imm_ext & wmask; end
      3'b100, 3'b110: begin cls = 3'd2; val = x_ext & wmask; end
      3'b101:         begin cls = 3'd3; val = box_ok ? (f_ext & wmask) : canon; end
      3'b111:         cls = 3'd4;
      default:        cls = 3'd0;
    endcase
    if (rsvd) val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalar_o <= '0;
      cls_o    <= '0;
      rsvd_o   <= 1'b0;
    end else begin
      scalar_o <= val;
      cls_o    <= cls;
      rsvd_o   <= rsvd;
    end
  end

  p_cls_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3_i == 3'b111) |=> (cls_o == 3'd4 && scalar_o == '0));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sew_i == 2'd0) |=> (scalar_o[63:8] == '0));

  p_imm_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3_i == 3'b011 && sew_i == 2'd3) |=>
      (scalar_o == {{59{$past(imm_i[4])}}, $past(imm_i)}));

  p_bad_frm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((funct3_i == 3'b001 || funct3_i == 3'b101) && frm_i >= 3'd5) |=> rsvd_o);

  p_int_never_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3_i[0] == 1'b0 || funct3_i == 3'b011 || funct3_i == 3'b111) |=> !rsvd_o);

  p_fp8_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3_i == 3'b101 && sew_i == 2'd0) |=> rsvd_o);

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_o |-> (scalar_o == '0));
endmodule

// File: tb/vec_scalar_fmt_tb.sv
`timescale 1ns/1ps
module vec_scalar_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  funct3_i = '0;
  logic [4:0]  imm_i = '0;
  logic [31:0] xreg_i = '0;
  logic [63:0] freg_i = '0;
  logic [1:0]  sew_i = '0;
  logic [2:0]  frm_i = '0;
  logic [2:0]  fp_ok_i = '0;
  logic [63:0] scalar_o;
  logic [2:0]  cls_o;
  logic        rsvd_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_scalar_fmt #(.XLEN(32), .FLEN(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .funct3_i(funct3_i), .imm_i(imm_i),
    .xreg_i(xreg_i), .freg_i(freg_i), .sew_i(sew_i), .frm_i(frm_i),
    .fp_ok_i(fp_ok_i), .scalar_o(scalar_o), .cls_o(cls_o), .rsvd_o(rsvd_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model(output logic [63:0] s, output logic [2:0] c, output logic r,
                       output string sreq);
    int w;
    bit fp, ok, boxed;
    w = 8 << sew_i;
    fp = (funct3_i == 3'd1) || (funct3_i == 3'd5);
    case (sew_i)
      2'd1: ok = fp_ok_i[0];
      2'd2: ok = fp_ok_i[1];
      2'd3: ok = fp_ok_i[2];
      default: ok = 0;
    endcase
    r = fp && (frm_i > 3'd4 || !ok);
    s = '0;
    sreq = "R10";
    case (funct3_i)
      3'd3: begin
        c = 3'd1; sreq = "R3";
        for (int i = 0; i < w; i++) s[i] = (i < 5) ? imm_i[i] : imm_i[4];
      end
      3'd4, 3'd6: begin
        c = 3'd2; sreq = (w <= 32) ? "R4" : "R5";
        for (int i = 0; i < w; i++) s[i] = (i < 32) ? xreg_i[i] : xreg_i[31];
      end
      3'd5: begin
        c = 3'd3;
        boxed = 1;
        for (int i = w; i < 64; i++) if (!freg_i[i]) boxed = 0;
        if (boxed) begin
          sreq = "R6";
          for (int i = 0; i < w; i++) s[i] = freg_i[i];
        end else begin
          sreq = "R7";
          s = (w == 16) ? 64'h7E00 : (w == 32) ? 64'h7FC00000 : 64'h7FF8000000000000;
        end
      end
      3'd7: c = 3'd4;
      default: c = 3'd0;
    endcase
    if (r) begin s = '0; sreq = "R10"; end
  endtask

  task automatic step;
    logic [63:0] s; logic [2:0] c; logic r; string sreq;
    model(s, c, r, sreq);
    @(posedge clk);
    @(negedge clk);
    chk({sreq, " scalar"}, scalar_o, s);
    chk("R1 class", {61'd0, cls_o}, {61'd0, c});
    chk((funct3_i == 3'd1 || funct3_i == 3'd5) ? "R8/R9 rsvd" : "R8 rsvd", {63'd0, rsvd_o}, {63'd0, r});
    if (sew_i != 2'd3) chk("R2 upper zero", scalar_o >> (8 << sew_i), 64'd0);
  endtask

  task automatic setin(input logic [2:0] f3, input logic [4:0] im, input logic [31:0] x,
                       input logic [63:0] f, input logic [1:0] sw, input logic [2:0] rm,
                       input logic [2:0] ok);
    funct3_i = f3; imm_i = im; xreg_i = x; freg_i = f; sew_i = sw; frm_i = rm; fp_ok_i = ok;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    setin(3'd3, 5'h1F, 32'hFFFF_FFFF, '1, 2'd3, 3'd0, 3'b111);
    repeat (3) @(negedge clk);
    chk("R11 reset scalar", scalar_o, 64'd0);
    chk("R11 reset class", {61'd0, cls_o}, 64'd0);
    chk("R11 reset rsvd", {63'd0, rsvd_o}, 64'd0);
    rst_n = 1'b1;

    setin(3'd3, 5'h10, 0, 0, 2'd3, 0, 3'b111); step;            // R3 negative imm
    setin(3'd3, 5'h0F, 0, 0, 2'd0, 0, 3'b111); step;            // R3 positive imm
    setin(3'd4, 0, 32'h8000_1234, 0, 2'd3, 0, 3'b111); step;    // R5 sign extend
    setin(3'd6, 0, 32'h8000_1234, 0, 2'd1, 7, 3'b111); step;    // R4 truncate, R8 frm ignored
    setin(3'd5, 0, 0, 64'hFFFF_FFFF_3F80_0000, 2'd2, 0, 3'b111); step; // R6
    setin(3'd5, 0, 0, 64'hFFFF_FFFE_3F80_0000, 2'd2, 0, 3'b111); step; // R7 32
    setin(3'd5, 0, 0, 64'h7FFF_FFFF_FFFF_3C00, 2'd1, 0, 3'b111); step; // R7 16
    setin(3'd5, 0, 0, 64'h0123_4567_89AB_CDEF, 2'd3, 0, 3'b111); step; // R6 64 always boxed
    setin(3'd1, 0, 0, 0, 2'd2, 3'd5, 3'b111); step;             // R8 non-rounding op
    setin(3'd5, 0, 0, '1, 2'd3, 3'd7, 3'b111); step;            // R8
    setin(3'd5, 0, 0, '1, 2'd1, 0, 3'b110); step;               // R9 16 unsupported
    setin(3'd1, 0, 0, 0, 2'd0, 0, 3'b111); step;                // R9 8-bit never
    setin(3'd7, 5'h1F, 32'hFFFF_FFFF, '1, 2'd3, 0, 3'b111); step; // R1 config
    setin(3'd0, 5'h1F, 32'hFFFF_FFFF, '1, 2'd3, 7, 3'b111); step; // R1 vv

    for (int n = 0; n < 600; n++) begin
      logic [63:0] f;
      f = {$urandom, $urandom};
      case ($urandom % 4)
        0: f[63:16] = '1;
        1: f[63:32] = '1;
        default: ;
      endcase
      setin(3'($urandom), 5'($urandom), $urandom, f, 2'($urandom),
            ($urandom % 4 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5), 3'($urandom | 1));
      step;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule